// File: doc/BRIEF.md
# Dual-Channel Power Sequencing Reset Controller

This block brings up two supply channels in a chosen order and holds an active-low reset for each until its supply has been good for a programmed number of clock cycles. It also drives the enable of a downstream watchdog once the resets that guard the processor have been released. A decoded three-level strap selects one of three sequencing schemes. The strap chooses whether channel 2 waits for channel 1, whether the two resets are merged into one, and which resets gate the watchdog.

The analog comparators feeding the two power-good flags sit outside the block, as do the strap decoder and the soft-start circuits. Each flag is high while its feedback voltage is above threshold. The strap code is captured while the block reset is high and is held until the next reset.

Top module: `pwr_seq_rst_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock after it is sampled high, all five outputs are 0.
- R2: The strap code on `strap_i` is captured on every clock edge while `rst` is high and is held after that. Changes to `strap_i` after reset have no effect. Code 2'b01 is the supply-tied scheme, 2'b00 is the ground-tied scheme and 2'b10 is the open scheme.
- R3: In the supply-tied and open schemes, a channel's reset output goes high once that channel's power-good flag has been sampled high on `PORx_CYCLES` consecutive clock edges. It stays high while the flag stays high.
- R4: When a power-good flag is low, that channel's reset is low in the same cycle, and its timeout count restarts from zero when the flag returns.
- R5: `run1_o` goes high on the first clock edge after reset is released and stays high.
- R6: In the supply-tied and ground-tied schemes, `run2_o` rises on the edge after `pgood1_i` is first sampled high. It then stays high even if `pgood1_i` falls.
- R7: In the open scheme, `run2_o` rises on the same edge as `run1_o`.
- R8: In the ground-tied scheme, both reset outputs are equal. They are high only when both flags are high and the channel 1 timeout has expired. The channel 2 timer has no effect.
- R9: `wdog_en_o` is high only when both resets are high in the supply-tied and ground-tied schemes, and only when `rst1_n_o` is high in the open scheme.
- R10: The undefined code 2'b11 behaves exactly like the ground-tied scheme.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; strap capture window |
| strap_i | input | 2 | Decoded sequencing strap code |
| pgood1_i | input | 1 | Channel 1 feedback above threshold |
| pgood2_i | input | 1 | Channel 2 feedback above threshold |
| run1_o | output | 1 | Channel 1 run enable |
| run2_o | output | 1 | Channel 2 run enable |
| rst1_n_o | output | 1 | Channel 1 reset, active low |
| rst2_n_o | output | 1 | Channel 2 reset, active low |
| wdog_en_o | output | 1 | Watchdog enable |

## Verification
The bench builds the block with `POR1_CYCLES` = 4 and `POR2_CYCLES` = 6. These short, unequal timeouts let both timers expire inside a few cycles. Because the values differ, a swap of the two timers or the use of the wrong timer in the merged scheme shows up on the outputs. The short windows also make it cheap to drop a flag just before and just after expiry. Each strap code is run through the same flag patterns in turn, so each scheme can be compared with the others under the same stimulus.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  typedef enum logic [1:0] {
    SEQ_GND   = 2'd0,
    SEQ_SUPPLY = 2'd1,
    SEQ_OPEN  = 2'd2
  } seq_mode_e;

  // R2 / R10: strap code to scheme, unknown codes fall back to the merged one
  function automatic seq_mode_e decode_strap(input logic [1:0] code);
    case (code)
      2'b01:   return SEQ_SUPPLY;
      2'b10:   return SEQ_OPEN;
      default: return SEQ_GND;
    endcase
  endfunction

  // R8: the merged-reset scheme
  function automatic logic resets_merged(input seq_mode_e m);
    return m == SEQ_GND;
  endfunction

  // R6 / R7: channel 2 may start without waiting for channel 1
  function automatic logic ch2_free_start(input seq_mode_e m);
    return m == SEQ_OPEN;
  endfunction

  // R9: watchdog gate
  function automatic logic wdog_gate(input seq_mode_e m, input logic r1n, input logic r2n);
    return (m == SEQ_OPEN) ? r1n : (r1n & r2n);
  endfunction

endpackage

// File: rtl/pseq_strap_latch.sv
module pseq_strap_latch
  import pseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic [1:0] code_i,
  output seq_mode_e mode_o
);

  seq_mode_e mode_q;

  // R2: load while in reset, hold afterwards
  always_ff @(posedge clk) begin
    if (rst) mode_q <= decode_strap(code_i);
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/pseq_por_timer.sv
module pseq_por_timer #(
  parameter int unsigned CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic pgood_i,
  output logic expired_o
);

  localparam int unsigned W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [W-1:0] LIMIT = W'(CYCLES);

  logic [W-1:0] cnt_q;

  // R3 / R4: count consecutive good edges, restart on any low flag
  always_ff @(posedge clk) begin
    if (rst || !arm_i || !pgood_i) cnt_q <= '0;
    else if (cnt_q != LIMIT)       cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LIMIT);

endmodule

// File: rtl/pseq_sequencer.sv
module pseq_sequencer
  import pseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  seq_mode_e mode_i,
  input  logic      pgood1_i,
  input  logic      pgood2_i,
  input  logic      expired1_i,
  input  logic      expired2_i,
  output logic      run1_o,
  output logic      run2_o,
  output logic      rst1_n_o,
  output logic      rst2_n_o,
  output logic      wdog_en_o
);

  logic run1_q, run2_q;
  logic ch1_ok, ch2_ok, merged_ok;

  // R5 / R6 / R7: run enables, channel 2 sticky once started
  always_ff @(posedge clk) begin
    if (rst) begin
      run1_q <= 1'b0;
      run2_q <= 1'b0;
    end else begin
      run1_q <= 1'b1;
      if (ch2_free_start(mode_i) || pgood1_i) run2_q <= 1'b1;
    end
  end

  // R4: flag gates the release directly, so a drop reasserts at once
  assign ch1_ok    = pgood1_i & expired1_i;
  assign ch2_ok    = pgood2_i & expired2_i;
  // R8: merged release uses channel 1 timer and channel 2 flag only
  assign merged_ok = ch1_ok & pgood2_i;

  assign rst1_n_o  = resets_merged(mode_i) ? merged_ok : ch1_ok;
  assign rst2_n_o  = resets_merged(mode_i) ? merged_ok : ch2_ok;
  assign wdog_en_o = wdog_gate(mode_i, rst1_n_o, rst2_n_o);
  assign run1_o    = run1_q;
  assign run2_o    = run2_q;

endmodule

// File: rtl/pwr_seq_rst_ctrl.sv
module pwr_seq_rst_ctrl
  import pseq_pkg::*;
#(
  parameter int unsigned POR1_CYCLES = 1000,
  parameter int unsigned POR2_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] strap_i,
  input  logic       pgood1_i,
  input  logic       pgood2_i,
  output logic       run1_o,
  output logic       run2_o,
  output logic       rst1_n_o,
  output logic       rst2_n_o,
  output logic       wdog_en_o
);

  localparam int NCH = 2;
  localparam int unsigned POR_CYC [NCH] = '{POR1_CYCLES, POR2_CYCLES};

  seq_mode_e        mode_q;
  logic [NCH-1:0]   pgood;
  logic [NCH-1:0]   arm;
  logic [NCH-1:0]   expired;

  assign pgood = {pgood2_i, pgood1_i};
  // R8: channel 2 timer idle in the merged scheme
  assign arm   = {~resets_merged(mode_q), 1'b1};

  pseq_strap_latch u_strap (
    .clk    (clk),
    .rst    (rst),
    .code_i (strap_i),
    .mode_o (mode_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_tmr
    pseq_por_timer #(.CYCLES(POR_CYC[i])) u_tmr (
      .clk       (clk),
      .rst       (rst),
      .arm_i     (arm[i]),
      .pgood_i   (pgood[i]),
      .expired_o (expired[i])
    );
  end

  pseq_sequencer u_seq (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_q),
    .pgood1_i   (pgood1_i),
    .pgood2_i   (pgood2_i),
    .expired1_i (expired[0]),
    .expired2_i (expired[1]),
    .run1_o     (run1_o),
    .run2_o     (run2_o),
    .rst1_n_o   (rst1_n_o),
    .rst2_n_o   (rst2_n_o),
    .wdog_en_o  (wdog_en_o)
  );

endmodule

// File: rtl/pseq_chk.sv
module pseq_chk
  import pseq_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input seq_mode_e mode_q,
  input logic      pgood1_i,
  input logic      pgood2_i,
  input logic      run1_o,
  input logic      run2_o,
  input logic      rst1_n_o,
  input logic      rst2_n_o,
  input logic      wdog_en_o
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!run1_o && !run2_o && !rst1_n_o && !rst2_n_o && !wdog_en_o));

  // R4
  drop1_chk: assert property (@(posedge clk) disable iff (rst)
    !pgood1_i |-> !rst1_n_o);

  // R4
  drop2_chk: assert property (@(posedge clk) disable iff (rst)
    !pgood2_i |-> !rst2_n_o);

  // R3
  release_needs_good_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst1_n_o) |-> $past(pgood1_i));

  // R5
  run1_hold_chk: assert property (@(posedge clk) disable iff (rst)
    run1_o |=> run1_o);

  // R6
  run2_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    run2_o |=> run2_o);

  // R7
  open_start_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == SEQ_OPEN && run1_o) |-> run2_o);

  // R8
  merged_equal_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == SEQ_GND) |-> (rst1_n_o == rst2_n_o));

  // R9
  wdog_gate_chk: assert property (@(posedge clk) disable iff (rst)
    wdog_en_o |-> rst1_n_o);

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_q));

endmodule

bind pwr_seq_rst_ctrl pseq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_q    (mode_q),
  .pgood1_i  (pgood1_i),
  .pgood2_i  (pgood2_i),
  .run1_o    (run1_o),
  .run2_o    (run2_o),
  .rst1_n_o  (rst1_n_o),
  .rst2_n_o  (rst2_n_o),
  .wdog_en_o (wdog_en_o)
);

// File: tb/pwr_seq_rst_ctrl_test.sv
module pwr_seq_rst_ctrl_test;

  localparam int P1 = 4;
  localparam int P2 = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] strap = 2'b00;
  logic pg1 = 1'b0, pg2 = 1'b0;
  logic run1, run2, r1n, r2n, wd;

  int checks = 0, fails = 0, cycles = 0;
  string phase = "R1";

  // model state: scheme 0 merged, 1 supply, 2 open
  int m_mode = 0, c1 = 0, c2 = 0;
  bit on1 = 0, on2 = 0;

  always #10 clk = ~clk;

  pwr_seq_rst_ctrl #(.POR1_CYCLES(P1), .POR2_CYCLES(P2)) uut (
    .clk(clk), .rst(rst), .strap_i(strap), .pgood1_i(pg1), .pgood2_i(pg2),
    .run1_o(run1), .run2_o(run2), .rst1_n_o(r1n), .rst2_n_o(r2n), .wdog_en_o(wd)
  );

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      // R2 / R10: code 01 supply, 10 open, anything else merged
      m_mode = (strap == 2'b01) ? 1 : (strap == 2'b10) ? 2 : 0;
      c1 = 0; c2 = 0; on1 = 0; on2 = 0;
    end else begin
      on1 = 1;
      if (m_mode == 2 || pg1) on2 = 1;
      c1 = pg1 ? ((c1 < P1) ? c1 + 1 : c1) : 0;
      c2 = (pg2 && m_mode != 0) ? ((c2 < P2) ? c2 + 1 : c2) : 0;
    end
  end

  task automatic cmp(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] t=%0t actual=%b expected=%b", req, phase, $time, act, exp);
    end
  endtask

  task automatic check_all();
    bit e1, e2, ew;
    if (m_mode == 0) begin
      e1 = pg1 && c1 >= P1 && pg2;   // R8
      e2 = e1;
    end else begin
      e1 = pg1 && c1 >= P1;          // R3 / R4
      e2 = pg2 && c2 >= P2;
    end
    ew = (m_mode == 2) ? e1 : (e1 && e2);
    cmp(rst ? "R1 run1" : "R5 run1", run1, on1);
    cmp(rst ? "R1 run2" : (m_mode == 2 ? "R7 run2" : "R6 run2"), run2, on2);
    cmp(m_mode == 0 ? "R8 rst1_n" : "R3 rst1_n", r1n, e1);
    cmp(m_mode == 0 ? "R8 rst2_n" : "R3 rst2_n", r2n, e2);
    cmp("R9 wdog_en", wd, ew);
  endtask

  task automatic step(input logic a, input logic b, input int n);
    pg1 = a; pg2 = b;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #5;
      check_all();
    end
  endtask

  task automatic do_reset(input logic [1:0] code, input string tag);
    phase = tag;
    rst = 1'b1; strap = code;
    step(1'b0, 1'b0, 3);   // R1 checked while in reset
    rst = 1'b0;
  endtask

  initial begin
    // supply-tied scheme
    do_reset(2'b01, "R2 supply");
    strap = 2'b10;         // R2: ignored after reset
    step(0, 0, 3);
    phase = "R6 supply";
    step(1, 0, 6);
    step(1, 1, 8);
    phase = "R4 supply";
    step(0, 1, 2);
    step(1, 1, 3);
    step(1, 0, 1);
    step(1, 1, 8);

    // ground-tied scheme
    do_reset(2'b00, "R8 gnd");
    step(0, 1, 3);
    step(1, 1, 6);
    step(1, 0, 2);
    step(1, 1, 3);
    step(0, 0, 2);
    step(1, 1, 2);
    step(0, 1, 1);
    step(1, 1, 6);

    // open scheme
    do_reset(2'b10, "R7 open");
    step(0, 0, 2);
    step(0, 1, 8);
    step(1, 1, 6);
    step(1, 0, 3);

    // undefined code
    do_reset(2'b11, "R10 undef");
    step(1, 0, 6);
    step(1, 1, 3);
    step(0, 1, 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule